// File: doc/BRIEF.md
# Programmable-Order CIC Decimator

This block is a cascaded integrator–comb decimator whose order is selected at run time, from 0 (a straight pass-through) up to 5, with a unit differential delay. A six-bit barrel shift brings the wide filter result back to the output width. The stage width grows with order and with decimation. The integrators therefore wrap in two's complement at a fixed accumulator width of `IN_W + N_MAX*(CNT_W+1)` bits, and the combs recover the exact result modulo that width.

Two sample enables drive the integrators. `en_first` clocks the first integrator, and `en_rest` clocks the later ones. For a time-multiplexed complex stream, the I word and the Q word each arrive with `en_first` high. Only the I word also carries `en_rest`, so the first integrator sums I and Q. A decimation counter counts `en_first` events. In complex mode it is loaded with twice the ratio. When it expires, the combs run once and one output sample is produced.

A small controller with three states owns the configuration:
- FLUSH clears every stage and loads the counter.
- RUN processes samples.
- FAULT holds the filter idle and raises `rate_err`.

The transitions are:
- reset → FLUSH.
- FLUSH → RUN when the counter load is at least 4.
- FLUSH → FAULT when the load is below 4.
- RUN → FLUSH and FAULT → FLUSH on any change of the configuration inputs.

Top module: `cic_decim`

## Requirements
- R1: While `rst_n` is low, `dout` is 0, `dout_valid` is 0 and `rate_err` is 0.
- R2: For an order N in 1..5, each output is the N-stage integrator cascade followed by N first-difference combs (delay 1) taken at the decimated instants. The arithmetic wraps at `IN_W + N_MAX*(CNT_W+1)` bits.
- R3: Order 0 with shift 45 is a bypass: each output equals the input sample presented on the terminal `en_first` cycle.
- R4: The output is the low `OUT_W` bits of (filter value × 2^45) arithmetically shifted right by `cfg_shift` (0..63).
- R5: The first integrator adds the input only on cycles with `en_first` high. Integrators 2..N add only on cycles with `en_rest` high, and they hold otherwise.
- R6: The counter counts `en_first` cycles in RUN. It expires every `cfg_ratio` events when `cfg_cplx` is 0, and every 2×`cfg_ratio` events when it is 1. `dout_valid` is high for one cycle, one clock after the expiring edge.
- R7: If the counter load (`cfg_ratio` or 2×`cfg_ratio`) is below 4, `rate_err` is 1 from two clocks after the configuration is applied, and no output is produced.
- R8: Any change of `cfg_order`, `cfg_shift`, `cfg_ratio` or `cfg_cplx` discards the input on that cycle and on the following cycle. It clears every integrator and comb and restarts the counter.
- R9: Order codes 6 and 7 behave as order 5.
- R10: `dout_valid` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_order | input | 3 | Filter order, 0..5 (6 and 7 act as 5) |
| cfg_shift | input | 6 | Right shift applied after a fixed left shift of 45 |
| cfg_ratio | input | CNT_W | Input samples (real) or complex pairs per output |
| cfg_cplx | input | 1 | 1 = two-word complex stream, counter load doubled |
| din | input | IN_W | Signed input sample |
| en_first | input | 1 | Enables the first integrator and the counter |
| en_rest | input | 1 | Enables integrators 2..5 |
| dout | output | OUT_W | Rescaled decimated sample, held between strobes |
| dout_valid | output | 1 | One-cycle strobe for a new `dout` |
| rate_err | output | 1 | Configured output rate exceeds a quarter of the clock |

## Verification
The assertions assume that the configuration inputs stay constant while in RUN. This is what makes the counter lie between 1 and the load, and what makes FAULT imply a too-fast setting. A change of any configuration input is itself a legal event that forces FLUSH, and the stimulus applies such changes freely, including mid-stream. The spacing assertion on `dout_valid` also relies on each `en_first` costing at least one clock, which holds by construction at the port. The bench reference model mirrors the flush semantics, so enables may stay active across configuration changes.

// File: rtl/cic_pkg.sv
package cic_pkg;
    typedef enum logic [1:0] {
        S_FLUSH = 2'd0,
        S_RUN   = 2'd1,
        S_FAULT = 2'd2
    } ctrl_state_e;

    localparam int BYPASS_SHIFT = 45;
    localparam int MIN_LOAD     = 4;
endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
    import cic_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int CFG_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [CNT_W-1:0] ratio,
    input  logic             cplx,
    input  logic             en_first,
    output logic             clear,
    output logic             run,
    output logic             terminal,
    output logic             rate_err
);
    localparam int LW = CNT_W + 1;

    ctrl_state_e      state, state_n;
    logic [CFG_W-1:0] cfg_q;
    logic [LW-1:0]    load, cnt;
    logic             chg, too_fast;

    assign chg      = (cfg_word != cfg_q);
    assign load     = cplx ? {ratio, 1'b0} : {1'b0, ratio};
    assign too_fast = (load < LW'(MIN_LOAD));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_FLUSH;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_FLUSH: state_n = too_fast ? S_FAULT : S_RUN;
            S_RUN:   state_n = S_RUN;
            S_FAULT: state_n = S_FAULT;
            default: state_n = S_FLUSH;
        endcase
        if (chg) state_n = S_FLUSH;
    end

    always_comb begin
        clear    = chg || (state != S_RUN);
        run      = !chg && (state == S_RUN);
        rate_err = (state == S_FAULT);
        terminal = run && en_first && (cnt == LW'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            cnt   <= '0;
        end else begin
            cfg_q <= cfg_word;
            if (clear)
                cnt <= load;
            else if (en_first)
                cnt <= (cnt == LW'(1)) ? load : cnt - LW'(1);
        end
    end

    // R6: while running the counter stays inside its reload window
    a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt >= LW'(1) && cnt <= load));

    // R7: a fault is only held for a too-fast setting
    a_r7_fault_reason: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FAULT && !chg) |-> too_fast);

    // R8: a configuration change always enters the flush state
    a_r8_flush_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (state == S_FLUSH));
endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
    parameter int ACC_W = 61,
    parameter int N_MAX = 5,
    parameter int ORD_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    run,
    input  logic                    en_first,
    input  logic                    en_rest,
    input  logic [ORD_W-1:0]        order,
    input  logic signed [ACC_W-1:0] x,
    output logic signed [ACC_W-1:0] tap
);
    logic signed [ACC_W-1:0] acc [N_MAX];
    logic signed [ACC_W-1:0] nxt [N_MAX];
    logic signed [ACC_W-1:0] t   [N_MAX+1];

    assign t[0] = x;

    for (genvar i = 0; i < N_MAX; i++) begin : g_stage
        logic signed [ACC_W-1:0] s_in;
        logic                    s_en;
        if (i == 0) begin : g_head
            assign s_in = x;
            assign s_en = en_first;
        end else begin : g_tail
            assign s_in = acc[i-1];
            assign s_en = en_rest;
        end
        assign nxt[i]  = s_en ? acc[i] + s_in : acc[i];
        assign t[i+1]  = nxt[i];
    end

    assign tap = t[order];

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_MAX; i++) begin
            if (!rst_n || clear) acc[i] <= '0;
            else if (run)        acc[i] <= nxt[i];
        end
    end

    // R5: the first integrator holds when its enable is low
    a_r5_first_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !en_first) |=> (acc[0] == $past(acc[0])));

    // R5: the second integrator holds when the shared enable is low
    a_r5_rest_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !en_rest) |=> (acc[1] == $past(acc[1])));
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
    parameter int ACC_W = 61,
    parameter int N_MAX = 5,
    parameter int ORD_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    step,
    input  logic [ORD_W-1:0]        order,
    input  logic signed [ACC_W-1:0] x,
    output logic signed [ACC_W-1:0] y
);
    logic signed [ACC_W-1:0] dly [N_MAX];
    logic signed [ACC_W-1:0] v   [N_MAX+1];

    assign v[0] = x;
    for (genvar i = 0; i < N_MAX; i++) begin : g_diff
        assign v[i+1] = v[i] - dly[i];
    end

    assign y = v[order];

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_MAX; i++) begin
            if (!rst_n || clear) dly[i] <= '0;
            else if (step)       dly[i] <= v[i];
        end
    end
endmodule

// File: rtl/cic_rescale.sv
module cic_rescale #(
    parameter int ACC_W = 61,
    parameter int OUT_W = 16,
    parameter int SH_W  = 6,
    parameter int PRE   = 45
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic [SH_W-1:0]         shift,
    output logic [OUT_W-1:0]        y
);
    logic signed [ACC_W+PRE-1:0] ext;

    assign ext = {acc, {PRE{1'b0}}};
    assign y   = OUT_W'(ext >>> shift);
endmodule

// File: rtl/cic_decim.sv
module cic_decim
    import cic_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 16,
    parameter int CNT_W = 8,
    parameter int N_MAX = 5,
    parameter int SH_W  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             cfg_order,
    input  logic [SH_W-1:0]        cfg_shift,
    input  logic [CNT_W-1:0]       cfg_ratio,
    input  logic                   cfg_cplx,
    input  logic [IN_W-1:0]        din,
    input  logic                   en_first,
    input  logic                   en_rest,
    output logic [OUT_W-1:0]       dout,
    output logic                   dout_valid,
    output logic                   rate_err
);
    localparam int ACC_W = IN_W + N_MAX * (CNT_W + 1);
    localparam int ORD_W = 3;
    localparam int CFG_W = 1 + CNT_W + SH_W + ORD_W;

    logic [ORD_W-1:0]        ord;
    logic signed [ACC_W-1:0] x_ext, integ_tap, comb_out;
    logic [OUT_W-1:0]        scaled;
    logic                    clear, run, terminal;

    assign ord   = (cfg_order > ORD_W'(N_MAX)) ? ORD_W'(N_MAX) : cfg_order;
    assign x_ext = {{(ACC_W-IN_W){din[IN_W-1]}}, din};

    cic_ctrl #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_word ({cfg_cplx, cfg_ratio, cfg_shift, cfg_order}),
        .ratio    (cfg_ratio),
        .cplx     (cfg_cplx),
        .en_first (en_first),
        .clear    (clear),
        .run      (run),
        .terminal (terminal),
        .rate_err (rate_err)
    );

    cic_integ_chain #(.ACC_W(ACC_W), .N_MAX(N_MAX), .ORD_W(ORD_W)) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .run      (run),
        .en_first (en_first),
        .en_rest  (en_rest),
        .order    (ord),
        .x        (x_ext),
        .tap      (integ_tap)
    );

    cic_comb_chain #(.ACC_W(ACC_W), .N_MAX(N_MAX), .ORD_W(ORD_W)) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .step  (terminal),
        .order (ord),
        .x     (integ_tap),
        .y     (comb_out)
    );

    cic_rescale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W), .PRE(BYPASS_SHIFT)) u_rescale (
        .acc   (comb_out),
        .shift (cfg_shift),
        .y     (scaled)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= terminal;
            if (terminal) dout <= scaled;
        end
    end

    // R10: strobes are never back to back
    a_r10_valid_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |=> !dout_valid);

    // R7: no output while the rate fault is raised
    a_r7_silent_fault: assert property (@(posedge clk) disable iff (!rst_n)
        rate_err |-> !dout_valid);
endmodule

// File: tb/cic_decim_bench.sv
module cic_decim_bench;
    localparam int IN_W  = 16;
    localparam int OUT_W = 16;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       cfg_order = 3'd0;
    logic [5:0]       cfg_shift = 6'd45;
    logic [CNT_W-1:0] cfg_ratio = 8'd4;
    logic             cfg_cplx = 1'b0;
    logic [IN_W-1:0]  din = '0;
    logic             en_first = 1'b0, en_rest = 1'b0;
    logic [OUT_W-1:0] dout;
    logic             dout_valid, rate_err;

    always #5 clk = ~clk;

    cic_decim u_cic_decim (
        .clk(clk), .rst_n(rst_n), .cfg_order(cfg_order), .cfg_shift(cfg_shift),
        .cfg_ratio(cfg_ratio), .cfg_cplx(cfg_cplx), .din(din),
        .en_first(en_first), .en_rest(en_rest),
        .dout(dout), .dout_valid(dout_valid), .rate_err(rate_err)
    );

    int    n_checks = 0, n_errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // Behavioural reference model
    logic [17:0]      m_cfg;
    int               m_phase;   // 0 running, 1 flushing, 2 faulted
    int               m_cnt;
    longint           mi [5];
    longint           md [5];
    bit               m_valid, prev_valid;
    logic [OUT_W-1:0] m_dout;
    bit               tog;

    function automatic logic [OUT_W-1:0] rescale(longint v, int sh);
        logic signed [127:0] w;
        w = {{67{v[60]}}, v[60:0]};
        w = w <<< 45;
        w = w >>> sh;
        return w[OUT_W-1:0];
    endfunction

    task automatic model_clear();
        for (int k = 0; k < 5; k++) begin mi[k] = 0; md[k] = 0; end
    endtask

    task automatic model_step();
        logic [17:0] cw;
        int ld, n;
        longint x, tap, v, t;
        longint ni [5];
        cw = {cfg_cplx, cfg_ratio, cfg_shift, cfg_order};
        ld = cfg_cplx ? 2 * int'(cfg_ratio) : int'(cfg_ratio);
        m_valid = 0;
        if (cw != m_cfg) begin
            m_cfg = cw; m_phase = 1; model_clear(); m_cnt = ld;
        end else if (m_phase == 1) begin
            model_clear(); m_cnt = ld; m_phase = (ld < 4) ? 2 : 0;
        end else if (m_phase == 0) begin
            n = (cfg_order > 5) ? 5 : int'(cfg_order);
            x = longint'($signed(din));
            ni[0] = en_first ? mi[0] + x : mi[0];
            for (int k = 1; k < 5; k++) ni[k] = en_rest ? mi[k] + mi[k-1] : mi[k];
            tap = (n == 0) ? x : ni[n-1];
            if (en_first) begin
                if (m_cnt == 1) begin
                    v = tap;
                    for (int k = 0; k < n; k++) begin t = v - md[k]; md[k] = v; v = t; end
                    m_dout = rescale(v, int'(cfg_shift));
                    m_valid = 1;
                    m_cnt = ld;
                end else m_cnt = m_cnt - 1;
            end
            for (int k = 0; k < 5; k++) mi[k] = ni[k];
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = '0; m_phase = 1; m_cnt = 0; m_valid = 0; m_dout = '0;
            model_clear();
        end else model_step();
    end

    task automatic chk(bit ok, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(dout_valid == m_valid, "dout_valid", dout_valid, m_valid);
        chk(rate_err == (m_phase == 2), "rate_err", rate_err, (m_phase == 2));
        if (m_valid) chk(dout == m_dout, "dout", dout, m_dout);
        if (cur_req == "R10") chk(!(dout_valid && prev_valid), "consecutive valid", dout_valid, 0);
        prev_valid = dout_valid;
    endtask

    // pat 0: both enables every cycle; 1: complex I/Q alternating;
    // 2: gapped real; 3: gapped complex; 4: independent random enables
    task automatic run(int cycles, int pat);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            compare();
            din = IN_W'($urandom);
            unique case (pat)
                0: begin en_first = 1; en_rest = 1; end
                1: begin en_first = 1; tog = !tog; en_rest = tog; end
                2: begin en_first = ($urandom % 3) != 0; en_rest = en_first; end
                3: begin
                    en_first = ($urandom % 3) != 0;
                    if (en_first) tog = !tog;
                    en_rest = en_first && tog;
                end
                default: begin en_first = $urandom % 2; en_rest = $urandom % 2; end
            endcase
        end
    endtask

    task automatic set_cfg(int o, int s, int r, bit c);
        cfg_order = 3'(o); cfg_shift = 6'(s); cfg_ratio = CNT_W'(r); cfg_cplx = c;
    endtask

    initial begin
        prev_valid = 0; tog = 0;
        // R1: reset state
        cur_req = "R1";
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk(dout == '0, "dout in reset", dout, 0);
            chk(dout_valid == 1'b0, "dout_valid in reset", dout_valid, 0);
            chk(rate_err == 1'b0, "rate_err in reset", rate_err, 0);
        end
        rst_n = 1;
        // R3: bypass
        cur_req = "R3"; set_cfg(0, 45, 4, 0); run(120, 0);
        // R2: each order with gapped input
        cur_req = "R2";
        for (int o = 1; o <= 5; o++) begin set_cfg(o, 45 - 3 * o, 8, 0); run(160, 2); end
        // R4: shift extremes
        cur_req = "R4";
        set_cfg(2, 0, 5, 0);  run(80, 0);
        set_cfg(2, 63, 5, 0); run(80, 0);
        set_cfg(2, 20, 5, 0); run(80, 0);
        // R5: split enables
        cur_req = "R5";
        set_cfg(3, 30, 4, 1); run(150, 1);
        set_cfg(4, 25, 6, 0); run(200, 4);
        // R6: complex doubling and long ratio
        cur_req = "R6";
        set_cfg(2, 40, 2, 1);   run(150, 3);
        set_cfg(1, 40, 255, 0); run(700, 0);
        set_cfg(3, 20, 255, 1); run(1200, 1);
        // R7: too-fast settings
        cur_req = "R7";
        set_cfg(1, 45, 3, 0); run(60, 0);
        set_cfg(2, 45, 1, 1); run(60, 1);
        set_cfg(0, 45, 0, 0); run(60, 0);
        set_cfg(1, 45, 4, 0); run(60, 0);
        // R8: changes mid-stream
        cur_req = "R8";
        for (int i = 0; i < 25; i++) begin
            set_cfg($urandom % 6, 20 + $urandom % 26, 4 + $urandom % 9, $urandom % 2);
            run(7 + $urandom % 9, 4);
        end
        // R9: out-of-range order codes
        cur_req = "R9";
        set_cfg(6, 28, 6, 0); run(120, 0);
        set_cfg(7, 28, 6, 0); run(120, 2);
        // R10: fastest legal rate
        cur_req = "R10";
        set_cfg(5, 35, 4, 0); run(150, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog %s: actual hung expected done", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule